// File: doc/BRIEF.md
# Vector Compare to Predicate Generator

This block turns a compare-and-branch into a vectorised predicate build. A command names two source registers with their vector lengths, a destination register for the predicate, the global vector length and a compare type. Each source is a vector when its length exceeds one and a scalar otherwise. The block walks the element indices one per cycle and reads both operands through an attached register file read port. It sets bit i of a bitfield to the compare result of element i, and writes the bitfield to the destination integer register once, at the end.

When both sources are scalar, no predicate is built. The block reads the two registers once and reports an ordinary branch-taken decision. Redirecting the program counter is left to the surrounding core.

The controller is a five-state machine. IDLE waits for `start`. From IDLE the machine takes one of three transitions: "scalar pair" goes to SCALAR, "empty vector" (VL of zero) goes straight to WRITE, and "vector walk" goes to LOOP. LOOP takes "next element" back to itself, or "last element" to WRITE. WRITE always moves to DONE, and both DONE and SCALAR return to IDLE.

Top module: `vcmp_pred_gen`

## Requirements
- R1: After reset, `busy`, `rf_we`, `done` and `br_valid` are all 0.
- R2: A source is a vector when its length input is greater than 1. A length of 0 or 1 makes it a scalar.
- R3: For element i, a vector source reads register (src + i) modulo NREG. A scalar source reads register src for every element.
- R4: Compare codes are: 0 equal, 1 not equal, 2 signed less-than, 3 signed greater-or-equal, 4 unsigned less-than, 5 unsigned greater-or-equal. Codes 6 and 7 always give false. Operand A is the left-hand side.
- R5: Bit i of the written predicate holds the compare result of element i for i < VL. All bits at or above VL are 0. A VL greater than XLEN is treated as XLEN.
- R6: One element is evaluated per cycle. With a start accepted at clock edge 0 and an effective VL of n ≥ 1, `rf_we` is high in the cycle after edge n. With VL of 0, `rf_we` is high in the cycle after edge 0.
- R7: A vector command produces exactly one write, to the destination register. `done` follows for exactly one cycle, in the cycle after the write.
- R8: When both sources are scalar, `br_valid` is high for one cycle in the cycle after edge 0, and `br_taken` carries the compare result. No register write and no `done` occur.
- R9: `start` is ignored while `busy` is high, and it does not change the running command's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted only when idle |
| src_a | input | AW | First source register number |
| src_b | input | AW | Second source register number |
| len_a | input | LW | Vector length of first source |
| len_b | input | LW | Vector length of second source |
| pdst | input | AW | Destination predicate register number |
| vl | input | LW | Global vector length |
| cmp_op | input | 3 | Compare type code |
| busy | output | 1 | Command in progress |
| rf_raddr_a | output | AW | Read address for operand A |
| rf_rdata_a | input | XLEN | Read data for operand A, same cycle |
| rf_raddr_b | output | AW | Read address for operand B |
| rf_rdata_b | input | XLEN | Read data for operand B, same cycle |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | AW | Register write address |
| rf_wdata | output | XLEN | Predicate bitfield written |
| done | output | 1 | One-cycle completion pulse for vector commands |
| br_valid | output | 1 | One-cycle pulse for a scalar-pair decision |
| br_taken | output | 1 | Branch decision, valid with br_valid |

## Verification
Random commands mix vector-vector, vector-scalar, scalar-vector and scalar-scalar operands over all eight compare codes. The register contents combine small repeated values with full-range words, so that equality and sign-dependent orderings both occur. These patterns tell a swapped operand, a wrong signedness or a wrong addressing stride apart from correct behaviour. Directed cases cover a VL of 0, a VL of exactly XLEN, a VL above XLEN, register wrap-around and lengths of 0 versus 1. These separate clamping, cleared-bit and classification faults. A second start injected mid-command shows that the block is not disturbed while busy.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
    typedef enum logic [2:0] {
        CMP_EQ  = 3'd0,
        CMP_NE  = 3'd1,
        CMP_LT  = 3'd2,
        CMP_GE  = 3'd3,
        CMP_LTU = 3'd4,
        CMP_GEU = 3'd5,
        CMP_RS6 = 3'd6,
        CMP_RS7 = 3'd7
    } cmp_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOP,
        S_SCALAR,
        S_WRITE,
        S_DONE
    } vstate_e;
endpackage

// File: rtl/vcmp_compare.sv
module vcmp_compare
    import vcmp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    input  logic [2:0]      op,
    output logic            hit
);
    always_comb begin
        unique case (cmp_op_e'(op))
            CMP_EQ:  hit = (lhs == rhs);
            CMP_NE:  hit = (lhs != rhs);
            CMP_LT:  hit = ($signed(lhs) <  $signed(rhs));
            CMP_GE:  hit = ($signed(lhs) >= $signed(rhs));
            CMP_LTU: hit = (lhs <  rhs);
            CMP_GEU: hit = (lhs >= rhs);
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/vcmp_elem_addr.sv
module vcmp_elem_addr #(
    parameter int AW = 5,
    parameter int IW = 6
) (
    input  logic [AW-1:0] base,
    input  logic          is_vec,
    input  logic [IW-1:0] idx,
    output logic [AW-1:0] addr
);
    localparam int SW = (AW > IW) ? AW : IW;
    logic [SW-1:0] sum;

    always_comb begin
        sum  = SW'(base) + SW'(idx);
        addr = is_vec ? sum[AW-1:0] : base;
    end
endmodule

// File: rtl/vcmp_pred_gen.sv
module vcmp_pred_gen
    import vcmp_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG),
    localparam int LW  = $clog2(XLEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   src_a,
    input  logic [AW-1:0]   src_b,
    input  logic [LW-1:0]   len_a,
    input  logic [LW-1:0]   len_b,
    input  logic [AW-1:0]   pdst,
    input  logic [LW-1:0]   vl,
    input  logic [2:0]      cmp_op,
    output logic            busy,
    output logic [AW-1:0]   rf_raddr_a,
    input  logic [XLEN-1:0] rf_rdata_a,
    output logic [AW-1:0]   rf_raddr_b,
    input  logic [XLEN-1:0] rf_rdata_b,
    output logic            rf_we,
    output logic [AW-1:0]   rf_waddr,
    output logic [XLEN-1:0] rf_wdata,
    output logic            done,
    output logic            br_valid,
    output logic            br_taken
);
    vstate_e         state_q, state_d;
    logic [LW-1:0]   idx_q, last_q;
    logic [AW-1:0]   base_a_q, base_b_q, pdst_q;
    logic            vec_a_q, vec_b_q;
    logic [2:0]      op_q;
    logic [XLEN-1:0] bits_q;
    logic [LW-1:0]   vl_eff;
    logic            hit;
    logic            cmd_vec_a, cmd_vec_b;

    assign vl_eff    = (vl > LW'(XLEN)) ? LW'(XLEN) : vl;
    assign cmd_vec_a = (len_a > LW'(1));
    assign cmd_vec_b = (len_b > LW'(1));

    vcmp_elem_addr #(.AW(AW), .IW(LW)) u_addr_a (
        .base(base_a_q), .is_vec(vec_a_q), .idx(idx_q), .addr(rf_raddr_a)
    );
    vcmp_elem_addr #(.AW(AW), .IW(LW)) u_addr_b (
        .base(base_b_q), .is_vec(vec_b_q), .idx(idx_q), .addr(rf_raddr_b)
    );
    vcmp_compare #(.XLEN(XLEN)) u_cmp (
        .lhs(rf_rdata_a), .rhs(rf_rdata_b), .op(op_q), .hit(hit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (!cmd_vec_a && !cmd_vec_b) state_d = S_SCALAR;
                    else if (vl_eff == '0)        state_d = S_WRITE;
                    else                          state_d = S_LOOP;
                end
            end
            S_LOOP:   state_d = (idx_q == last_q) ? S_WRITE : S_LOOP;
            S_SCALAR: state_d = S_IDLE;
            S_WRITE:  state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // command and bitfield registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            last_q   <= '0;
            base_a_q <= '0;
            base_b_q <= '0;
            pdst_q   <= '0;
            vec_a_q  <= 1'b0;
            vec_b_q  <= 1'b0;
            op_q     <= '0;
            bits_q   <= '0;
        end else if (state_q == S_IDLE && start) begin
            idx_q    <= '0;
            last_q   <= vl_eff - LW'(1);
            base_a_q <= src_a;
            base_b_q <= src_b;
            pdst_q   <= pdst;
            vec_a_q  <= cmd_vec_a;
            vec_b_q  <= cmd_vec_b;
            op_q     <= cmp_op;
            bits_q   <= '0;
        end else if (state_q == S_LOOP) begin
            bits_q <= bits_q | (XLEN'(hit) << idx_q);
            if (idx_q != last_q) idx_q <= idx_q + LW'(1);
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != S_IDLE);
        rf_we    = (state_q == S_WRITE);
        rf_waddr = pdst_q;
        rf_wdata = bits_q;
        done     = (state_q == S_DONE);
        br_valid = (state_q == S_SCALAR);
        br_taken = (state_q == S_SCALAR) && hit;
    end
endmodule

// File: rtl/vcmp_pred_gen_chk.sv
module vcmp_pred_gen_chk #(
    parameter int AW   = 5,
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            rf_we,
    input logic [AW-1:0]   rf_waddr,
    input logic [XLEN-1:0] rf_wdata,
    input logic            done,
    input logic            br_valid
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !rf_we && !done && !br_valid));

    assert_write_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> (done && !rf_we));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_branch_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> (!rf_we && !done));

    assert_branch_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> ($past(start) && !$past(busy)));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> !br_valid);
endmodule

bind vcmp_pred_gen vcmp_pred_gen_chk #(.AW(AW), .XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .done(done), .br_valid(br_valid)
);

// File: tb/vcmp_pred_gen_bench.sv
`timescale 1ns/1ps
module vcmp_pred_gen_bench;
    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int AW   = 5;
    localparam int LW   = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [AW-1:0]   src_a = '0, src_b = '0, pdst = '0;
    logic [LW-1:0]   len_a = '0, len_b = '0, vl = '0;
    logic [2:0]      cmp_op = '0;
    logic            busy, rf_we, done, br_valid, br_taken;
    logic [AW-1:0]   rf_raddr_a, rf_raddr_b, rf_waddr;
    logic [XLEN-1:0] rf_rdata_a, rf_rdata_b, rf_wdata;
    logic [XLEN-1:0] rf [NREG];

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    assign rf_rdata_a = rf[rf_raddr_a];
    assign rf_rdata_b = rf[rf_raddr_b];
    always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

    vcmp_pred_gen #(.XLEN(XLEN), .NREG(NREG)) u_vcmp_pred_gen (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_a(src_a), .src_b(src_b), .len_a(len_a), .len_b(len_b),
        .pdst(pdst), .vl(vl), .cmp_op(cmp_op), .busy(busy),
        .rf_raddr_a(rf_raddr_a), .rf_rdata_a(rf_rdata_a),
        .rf_raddr_b(rf_raddr_b), .rf_rdata_b(rf_rdata_b),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .done(done), .br_valid(br_valid), .br_taken(br_taken)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit ref_cmp(logic [XLEN-1:0] a, logic [XLEN-1:0] b, logic [2:0] op);
        case (op)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd2: return $signed(a) <  $signed(b);
            3'd3: return $signed(a) >= $signed(b);
            3'd4: return a < b;
            3'd5: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] ref_pred(int sa, int la, int sb, int lb, int v, logic [2:0] op);
        logic [XLEN-1:0] r = '0;
        int n = (v > XLEN) ? XLEN : v;
        for (int i = 0; i < n; i++) begin
            logic [XLEN-1:0] ea = (la > 1) ? rf[(sa + i) % NREG] : rf[sa];
            logic [XLEN-1:0] eb = (lb > 1) ? rf[(sb + i) % NREG] : rf[sb];
            r[i] = ref_cmp(ea, eb, op);
        end
        return r;
    endfunction

    task automatic run_cmd(input int sa, input int la, input int sb, input int lb,
                           input int pd, input int v, input int op, input bit inject);
        bit scalar = (la <= 1) && (lb <= 1);
        int n = (v > XLEN) ? XLEN : v;
        int exp_we_k = (n == 0) ? 1 : n + 1;
        logic [XLEN-1:0] exp_bits = ref_pred(sa, la, sb, lb, v, 3'(op));
        bit exp_br = ref_cmp(rf[sa], rf[sb], 3'(op));
        int we_cnt = 0, we_k = -1, done_cnt = 0, done_k = -1, br_cnt = 0, br_k = -1;
        logic [XLEN-1:0] got_data = '0;
        logic [AW-1:0]   got_addr = '0;
        bit got_taken = 1'b0;

        @(negedge clk);
        src_a = AW'(sa); len_a = LW'(la); src_b = AW'(sb); len_b = LW'(lb);
        pdst = AW'(pd); vl = LW'(v); cmp_op = 3'(op); start = 1'b1;
        for (int k = 1; k <= n + 6; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (inject && k == 1) begin
                start = 1'b1;
                src_a = AW'($urandom); src_b = AW'($urandom); len_a = 0; len_b = 0;
                pdst = AW'($urandom); vl = LW'($urandom % 33); cmp_op = 3'($urandom);
            end
            if (rf_we) begin we_cnt++; we_k = k; got_data = rf_wdata; got_addr = rf_waddr; end
            if (done) begin done_cnt++; done_k = k; end
            if (br_valid) begin br_cnt++; br_k = k; got_taken = br_taken; end
        end
        start = 1'b0;
        if (scalar) begin
            check(br_cnt == 1 && br_k == 1, "R8 branch pulse timing", br_k, 1);
            check(got_taken == exp_br, "R8/R4 branch decision", got_taken, exp_br);
            check(we_cnt == 0 && done_cnt == 0, "R8 no write or done", we_cnt + done_cnt, 0);
        end else begin
            check(we_cnt == 1, "R7 single write", we_cnt, 1);
            check(we_k == exp_we_k, "R6 write cycle", we_k, exp_we_k);
            check(got_addr == AW'(pd), "R7 write address", got_addr, pd);
            check(got_data == exp_bits, "R5/R4/R3 predicate bits", got_data, exp_bits);
            check(done_cnt == 1 && done_k == exp_we_k + 1, "R7 done pulse", done_k, exp_we_k + 1);
            check(br_cnt == 0, "R2 no branch for vector", br_cnt, 0);
        end
        if (inject) check(!busy, "R9 injected start ignored", busy, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NREG; i++)
            rf[i] = (i % 3 == 0) ? XLEN'($urandom % 4) : XLEN'($urandom);
        rf[7] = 32'h8000_0000; rf[8] = 32'h7fff_ffff;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !rf_we && !done && !br_valid, "R1 reset state",
              {busy, rf_we, done, br_valid}, 0);
        rst_n = 1'b1;

        // directed corner cases
        run_cmd(3, 4, 6, 4, 20, 8, 0, 0);   // R3 vector-vector equal
        run_cmd(7, 1, 8, 0, 0, 5, 2, 0);    // R8 scalar pair, signed lt
        run_cmd(7, 1, 8, 1, 0, 5, 4, 0);    // R8 scalar pair, unsigned lt
        run_cmd(7, 0, 8, 0, 0, 5, 6, 0);    // R4 code 6 false
        run_cmd(7, 2, 8, 1, 21, 3, 3, 0);   // R2 len 2 is vector
        run_cmd(2, 5, 9, 1, 22, 0, 1, 0);   // R5 VL zero
        run_cmd(0, 32, 9, 1, 23, 32, 5, 0); // R5 VL = XLEN
        run_cmd(1, 40, 4, 40, 24, 40, 1, 0);// R5 VL clamped
        run_cmd(30, 4, 28, 4, 25, 5, 3, 0); // R3 wrap-around
        run_cmd(5, 3, 5, 1, 5, 4, 7, 0);    // R4 code 7 false, pdst overlaps
        run_cmd(4, 3, 10, 3, 26, 6, 1, 1);  // R9 start during busy
        run_cmd(7, 1, 8, 1, 0, 1, 3, 1);    // R9 start during scalar

        // constrained random
        for (int t = 0; t < 60; t++) begin
            int la = ($urandom % 3 == 0) ? int'($urandom % 2) : int'($urandom % 33);
            int lb = ($urandom % 3 == 0) ? int'($urandom % 2) : int'($urandom % 33);
            run_cmd($urandom % NREG, la, $urandom % NREG, lb, $urandom % NREG,
                    $urandom % 41, $urandom % 8, ($urandom % 5) == 0);
        end
        repeat (3) @(negedge clk);
        summary();
    end
endmodule